// File: doc/BRIEF.md
# Nonvolatile Backup Sequencer

This controller sits beside a word-wide SRAM array and a shadow array that stands in for the nonvolatile cells. It runs two transfers. A save copies every SRAM word into the shadow. A restore first clears the SRAM and then loads it from the shadow. A save starts from one of three sources: a power-fail input, an external low pulse on the shared handshake pin, or a one-cycle software request. A restore starts after reset, after a power-down episode ends, or on a software request. While a transfer runs, the host port is closed.

The handshake pin is a single open-drain line that works in both directions. The block pulls it low for the whole of a save and reads it back as a request input. After a save, the host stays locked out until the pin has been seen high for a recovery interval. A sticky "written since last save" flag lets an external pulse be dropped when there is nothing new to save. All durations are counted in clock cycles and set by parameters.

Top module: `nvb_ctrl`

## Requirements
- R1: After reset, `host_ready` stays low for max(2·DEPTH, RCL_CYC) cycles while a restore runs, and then goes high. DEPTH is 2^ADDR_W.
- R2: A restore takes the same max(2·DEPTH, RCL_CYC) cycles. It first writes zero to every SRAM word and then copies the shadow into the SRAM, leaving the shadow unchanged. A second restore therefore returns the same data.
- R3: A software save pulls `hsb_oe` high for one pre-save cycle (host idle) plus max(DEPTH, STORE_CYC) save cycles, and releases it only when the save has finished. The shadow then holds the SRAM contents.
- R4: After any save that was not caused by a power fail, `host_ready` stays low as long as `hsb_in` is low. Once the pin is high, `host_ready` goes high after RECOV_CYC consecutive high cycles. A low sample during that count restarts the wait.
- R5: When `pwr_fail` is high in idle, `hsb_oe` is high on the next cycle and a save follows. Afterwards the block stays closed with the pin released until `pwr_fail` falls, and then it runs a restore.
- R6: During the pre-save window the host port stays open while `host_en` is held, for at most DRAIN_CYC cycles. Writes made in that window are included in the save.
- R7: In idle, an external save request is `hsb_in` sampled low on PULSE_MIN consecutive cycles. A shorter low pulse starts nothing.
- R8: The dirty flag is set by an accepted host write and cleared when a save or a restore completes. A valid external pulse while the flag is clear is skipped.
- R9: Requests are taken only in idle. A software request during a save, restore or lockout has no effect.
- R10: A power fail during a restore abandons it and enters power-down without saving. The restore runs again once `pwr_fail` falls.
- R11: `host_ready` is high only in idle and in the pre-save window. A read accepted on one edge presents its data on `host_rdata` after that edge. In idle the priority is power fail, then external pulse, then software save, then software restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; a restore follows its release |
| pwr_fail | input | 1 | Supply failing (digital) |
| sw_store | input | 1 | One-cycle software save request |
| sw_recall | input | 1 | One-cycle software restore request |
| hsb_in | input | 1 | Resolved level of the open-drain handshake pin |
| hsb_oe | output | 1 | Pull the handshake pin low |
| host_en | input | 1 | Host cycle active |
| host_we | input | 1 | Host cycle is a write |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data, registered |
| host_ready | output | 1 | Host cycles are accepted |

## Verification
The bench builds the block with ADDR_W=4 (16 words), STORE_CYC=40, RCL_CYC=40, DRAIN_CYC=4, PULSE_MIN=3 and RECOV_CYC=5. With these values every save and restore lasts only a few dozen cycles, so one run can measure exact pin-low and lockout lengths many times. Sixteen words let the bench fill and read back the whole array. A parameter set where RCL_CYC exceeds 2·DEPTH makes the load phase longer than a plain copy, which exposes off-by-one faults in each phase counter.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

  typedef enum logic [2:0] {
    ST_RCL_CLR,
    ST_RCL_LD,
    ST_IDLE,
    ST_DRAIN,
    ST_STORE,
    ST_LOCK,
    ST_RECOV,
    ST_DOWN
  } nvb_state_e;

  function automatic int unsigned longer(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Load-phase length so that clear + load spans the restore duration.
  function automatic int unsigned load_len(input int unsigned rcl, input int unsigned depth);
    return (rcl > 2 * depth) ? rcl - depth : depth;
  endfunction

endpackage

// File: rtl/nvb_phase_timer.sv
module nvb_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/nvb_pin_filter.sv
module nvb_pin_filter #(
  parameter int unsigned PULSE_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic pin,
  output logic trig
);
  localparam int unsigned LW = $clog2(PULSE_MIN + 1);

  logic [LW-1:0] low_cnt;

  // Fires once, on the PULSE_MIN-th consecutive low sample.
  assign trig = arm && !pin && (low_cnt == LW'(PULSE_MIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_cnt <= '0;
    else if (!arm || pin)                low_cnt <= '0;
    else if (low_cnt != LW'(PULSE_MIN))  low_cnt <= low_cnt + LW'(1);
  end
endmodule

// File: rtl/nvb_mem.sv
module nvb_mem #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              sram_we,
  input  logic [ADDR_W-1:0] sram_wa,
  input  logic [DATA_W-1:0] sram_wd,
  input  logic [ADDR_W-1:0] sram_ra,
  output logic [DATA_W-1:0] sram_rd,
  input  logic              sh_we,
  input  logic [ADDR_W-1:0] sh_a,
  input  logic [DATA_W-1:0] sh_wd,
  output logic [DATA_W-1:0] sh_rd
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] sram   [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];

  always_ff @(posedge clk) begin
    if (sram_we) sram[sram_wa] <= sram_wd;
    if (sh_we)   shadow[sh_a]  <= sh_wd;
  end

  assign sram_rd = sram[sram_ra];
  assign sh_rd   = shadow[sh_a];
endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
  import nvb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STORE_CYC = 2000,
  parameter int unsigned RCL_CYC   = 1100,
  parameter int unsigned DRAIN_CYC = 8,
  parameter int unsigned PULSE_MIN = 2,
  parameter int unsigned RECOV_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_fail,
  input  logic              sw_store,
  input  logic              sw_recall,
  input  logic              hsb_in,
  output logic              hsb_oe,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ready
);
  localparam int unsigned DEPTH     = 1 << ADDR_W;
  localparam int unsigned STORE_LEN = longer(DEPTH, STORE_CYC);
  localparam int unsigned LD_LEN    = load_len(RCL_CYC, DEPTH);
  localparam int unsigned MAX_LEN   = longer(longer(STORE_LEN, LD_LEN), longer(DRAIN_CYC, RECOV_CYC));
  localparam int unsigned CNT_W     = $clog2(MAX_LEN + 1);

  nvb_state_e state, state_nx;
  logic             from_pf, dirty;
  logic [CNT_W-1:0] phase_cnt;

  function automatic logic at_end(input logic [CNT_W-1:0] c, input int unsigned len);
    return c == CNT_W'(len - 1);
  endfunction

  // Named internal events
  logic in_idle, in_drain, in_store, in_recall, in_lock, in_down;
  logic store_done, recall_done, hw_trig, host_acc, in_range;
  logic shadow_we, sram_we;
  logic [ADDR_W-1:0] cnt_addr, sram_wa, sram_ra;
  logic [DATA_W-1:0] sram_wd, sram_rd, sh_rd;

  assign in_idle     = (state == ST_IDLE);
  assign in_drain    = (state == ST_DRAIN);
  assign in_store    = (state == ST_STORE);
  assign in_recall   = (state == ST_RCL_CLR) || (state == ST_RCL_LD);
  assign in_lock     = (state == ST_LOCK) || (state == ST_RECOV);
  assign in_down     = (state == ST_DOWN);
  assign store_done  = in_store && at_end(phase_cnt, STORE_LEN);
  assign recall_done = (state == ST_RCL_LD) && at_end(phase_cnt, LD_LEN);
  assign in_range    = phase_cnt < CNT_W'(DEPTH);
  assign cnt_addr    = phase_cnt[ADDR_W-1:0];

  assign host_ready = in_idle || in_drain;
  assign host_acc   = host_en && host_ready;
  assign hsb_oe     = in_drain || in_store;

  nvb_pin_filter #(.PULSE_MIN(PULSE_MIN)) u_filt (
    .clk(clk), .rst_n(rst_n), .arm(in_idle), .pin(hsb_in), .trig(hw_trig)
  );

  nvb_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(state_nx != state), .cnt(phase_cnt)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RCL_CLR: if (pwr_fail) state_nx = ST_DOWN;
                  else if (at_end(phase_cnt, DEPTH)) state_nx = ST_RCL_LD;
      ST_RCL_LD:  if (pwr_fail) state_nx = ST_DOWN;
                  else if (recall_done) state_nx = ST_IDLE;
      ST_IDLE:    if (pwr_fail || (hw_trig && dirty) || sw_store) state_nx = ST_DRAIN;
                  else if (sw_recall) state_nx = ST_RCL_CLR;
      ST_DRAIN:   if (!host_en || at_end(phase_cnt, DRAIN_CYC)) state_nx = ST_STORE;
      ST_STORE:   if (store_done) state_nx = from_pf ? ST_DOWN : ST_LOCK;
      ST_LOCK:    if (hsb_in) state_nx = ST_RECOV;
      ST_RECOV:   if (!hsb_in) state_nx = ST_LOCK;
                  else if (at_end(phase_cnt, RECOV_CYC)) state_nx = ST_IDLE;
      ST_DOWN:    if (!pwr_fail) state_nx = ST_RCL_CLR;
      default:    state_nx = ST_RCL_CLR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RCL_CLR;
      from_pf <= 1'b0;
      dirty   <= 1'b0;
    end else begin
      state <= state_nx;
      if (in_idle) from_pf <= pwr_fail;
      if (store_done || recall_done)  dirty <= 1'b0;
      else if (host_acc && host_we)   dirty <= 1'b1;
    end
  end

  // Array port steering
  assign sram_we   = (host_acc && host_we) || (state == ST_RCL_CLR) ||
                     ((state == ST_RCL_LD) && in_range);
  assign sram_wa   = in_recall ? cnt_addr : host_addr;
  assign sram_wd   = (state == ST_RCL_CLR) ? '0 :
                     (state == ST_RCL_LD)  ? sh_rd : host_wdata;
  assign sram_ra   = in_store ? cnt_addr : host_addr;
  assign shadow_we = in_store && in_range;

  nvb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .sram_we(sram_we), .sram_wa(sram_wa), .sram_wd(sram_wd),
    .sram_ra(sram_ra), .sram_rd(sram_rd), .sh_we(shadow_we), .sh_a(cnt_addr),
    .sh_wd(sram_rd), .sh_rd(sh_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      host_rdata <= '0;
    else if (host_acc && !host_we)   host_rdata <= sram_rd;
  end
endmodule

// File: rtl/nvb_ctrl_chk.sv
module nvb_ctrl_chk #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned DRAIN_CYC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_fail,
  input logic             sw_store,
  input logic             sw_recall,
  input logic             hsb_in,
  input logic             hsb_oe,
  input logic             host_ready,
  input logic             in_idle,
  input logic             in_drain,
  input logic             in_store,
  input logic             in_recall,
  input logic             in_lock,
  input logic             in_down,
  input logic             store_done,
  input logic             hw_trig,
  input logic             dirty,
  input logic             shadow_we,
  input logic [CNT_W-1:0] phase_cnt
);
  p_store_pin_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_store |-> hsb_oe);

  p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lock && !hsb_in) |=> !host_ready);

  p_pf_quick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && pwr_fail) |=> hsb_oe);

  p_drain_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_drain |-> (phase_cnt < CNT_W'(DRAIN_CYC)));

  p_hw_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && hw_trig && !dirty && !pwr_fail && !sw_store && !sw_recall) |=> in_idle);

  p_dirty_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    store_done |=> !dirty);

  p_recall_keeps_shadow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_recall |-> !shadow_we);

  p_pf_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_recall && pwr_fail) |=> in_down);

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_store && !store_done && (sw_store || sw_recall)) |=> in_store);

  p_closed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_store || in_recall || in_down || in_lock) |-> !host_ready);
endmodule

bind nvb_ctrl nvb_ctrl_chk #(.CNT_W(CNT_W), .DRAIN_CYC(DRAIN_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .sw_store(sw_store),
  .sw_recall(sw_recall), .hsb_in(hsb_in), .hsb_oe(hsb_oe), .host_ready(host_ready),
  .in_idle(in_idle), .in_drain(in_drain), .in_store(in_store), .in_recall(in_recall),
  .in_lock(in_lock), .in_down(in_down), .store_done(store_done), .hw_trig(hw_trig),
  .dirty(dirty), .shadow_we(shadow_we), .phase_cnt(phase_cnt)
);

// File: tb/tb_nvb_ctrl.sv
`timescale 1ns/1ps
module tb_nvb_ctrl;
  localparam int AW = 4, DW = 8, DEPTH = 16;
  localparam int STORE_TB = 40, RCL_TB = 40, DRAIN_TB = 4, PULSE_TB = 3, RECOV_TB = 5;
  // Expected durations in samples, from the requirements
  localparam int PIN_N  = 1 + ((STORE_TB > DEPTH) ? STORE_TB : DEPTH);
  localparam int LOCK_N = 1 + RECOV_TB;
  localparam int RCL_N  = (RCL_TB > 2 * DEPTH) ? RCL_TB : 2 * DEPTH;

  logic clk = 0, rst_n = 0, pwr_fail = 0, sw_store = 0, sw_recall = 0, ext_low = 0;
  logic host_en = 0, host_we = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0, host_rdata;
  logic hsb_oe, host_ready, hsb_in;

  assign hsb_in = ~(hsb_oe | ext_low);
  always #4 clk = ~clk;

  nvb_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYC(STORE_TB), .RCL_CYC(RCL_TB),
             .DRAIN_CYC(DRAIN_TB), .PULSE_MIN(PULSE_TB), .RECOV_CYC(RECOV_TB)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .sw_store(sw_store),
    .sw_recall(sw_recall), .hsb_in(hsb_in), .hsb_oe(hsb_oe), .host_en(host_en),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_ready(host_ready));

  int checks = 0, fails = 0;
  logic [DW-1:0] sram_m [DEPTH];
  logic [DW-1:0] shadow_m [DEPTH];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  logic rd_acc = 0;

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(posedge clk) rd_acc <= host_en && !host_we && host_ready;
  always @(negedge clk) begin
    if (rd_acc) begin
      if (exp_q.size() == 0) chk("R11", 1, 0, "unexpected read data");
      else chk(tag_q.pop_front(), int'(host_rdata), int'(exp_q.pop_front()), "read data");
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic do_write(input int a, input int d);
    host_en = 1; host_we = 1; host_addr = AW'(a); host_wdata = DW'(d);
    tick(); host_en = 0; host_we = 0; sram_m[a] = DW'(d);
  endtask
  task automatic do_read(input int a, input string tag);
    host_en = 1; host_we = 0; host_addr = AW'(a);
    exp_q.push_back(sram_m[a]); tag_q.push_back(tag);
    tick(); host_en = 0;
  endtask
  task automatic model_store(); for (int i = 0; i < DEPTH; i++) shadow_m[i] = sram_m[i]; endtask
  task automatic model_recall(); for (int i = 0; i < DEPTH; i++) sram_m[i] = shadow_m[i]; endtask
  task automatic count_oe(output int n, input bit poke);
    n = 0;
    while (hsb_oe && n < 100000) begin
      n++; sw_recall = poke && (n == 10); tick();
    end
    sw_recall = 0;
  endtask
  task automatic count_closed(output int n);
    n = 0;
    while (!host_ready && n < 100000) begin n++; tick(); end
  endtask
  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    repeat (3) tick();
    chk("R1", host_ready, 0, "ready in reset");
    chk("R3", hsb_oe, 0, "pin drive in reset");
    rst_n = 1;
    count_closed(n); chk("R1", n, RCL_N, "power-up restore length");

    for (int i = 0; i < DEPTH; i++) do_write(i, i * 7 + 3);
    do_read(0, "R11"); do_read(9, "R11"); do_read(15, "R11");

    sw_store = 1; tick(); sw_store = 0;
    count_oe(n, 1); chk("R3", n, PIN_N, "save pin-low length");
    model_store();
    count_closed(n); chk("R9", n, LOCK_N, "lockout with ignored restore request");

    for (int i = 0; i < DEPTH; i++) do_write(i, i ^ 8'h5C);
    sw_recall = 1; tick(); sw_recall = 0;
    count_closed(n); chk("R2", n, RCL_N, "restore length");
    model_recall();
    for (int i = 0; i < DEPTH; i++) do_read(i, "R2");
    sw_recall = 1; tick(); sw_recall = 0;
    count_closed(n); chk("R2", n, RCL_N, "second restore length");
    model_recall();
    do_read(1, "R2"); do_read(14, "R2");

    ext_low = 1;
    repeat (4) begin
      tick();
      chk("R8", hsb_oe, 0, "clean pulse skipped");
      chk("R8", host_ready, 1, "clean pulse keeps host open");
    end
    ext_low = 0; tick();

    do_write(0, 8'hA5);
    ext_low = 1; tick(); tick(); ext_low = 0;
    chk("R7", hsb_oe, 0, "short pulse ignored");
    tick(); chk("R7", host_ready, 1, "short pulse keeps host open");
    ext_low = 1; tick(); tick(); tick(); ext_low = 0;
    chk("R7", hsb_oe, 1, "valid pulse starts save");
    count_oe(n, 0); chk("R7", n, PIN_N, "pulse save pin-low length");
    model_store();
    count_closed(n); chk("R4", n, LOCK_N, "lockout after pulse save");

    do_write(1, 8'h3C);
    sw_store = 1; tick(); sw_store = 0;
    repeat (5) tick();
    ext_low = 1;
    count_oe(n, 0); model_store();
    repeat (10) begin chk("R4", host_ready, 0, "locked while pin held low"); tick(); end
    ext_low = 0;
    count_closed(n); chk("R4", n, LOCK_N, "release after pin high");

    host_en = 1; host_we = 1; host_addr = 4'd2; host_wdata = 8'h77;
    sw_store = 1; tick(); sw_store = 0; sram_m[2] = 8'h77;
    n = 0;
    while (host_ready && hsb_oe && n < 100) begin n++; tick(); end
    chk("R6", n, DRAIN_TB, "pre-save window length");
    host_en = 0; host_we = 0;
    count_oe(n, 0); model_store();
    count_closed(n);
    sw_recall = 1; tick(); sw_recall = 0;
    count_closed(n); model_recall();
    do_read(2, "R6");

    do_write(3, 8'h5A);
    pwr_fail = 1; tick();
    chk("R5", hsb_oe, 1, "pin low one cycle after power fail");
    count_oe(n, 0); chk("R5", n, PIN_N, "power-fail save length");
    model_store();
    repeat (8) begin
      chk("R5", host_ready, 0, "closed in power-down");
      chk("R5", hsb_oe, 0, "pin released in power-down");
      tick();
    end
    pwr_fail = 0;
    count_closed(n); chk("R5", n, 1 + RCL_N, "restore after power returns");
    model_recall();
    do_read(3, "R5");

    do_write(4, 8'h11);
    sw_recall = 1; tick(); sw_recall = 0;
    repeat (9) tick();
    pwr_fail = 1; tick();
    chk("R10", host_ready, 0, "closed after abort");
    repeat (5) begin chk("R10", hsb_oe, 0, "no save on abort"); tick(); end
    pwr_fail = 0;
    count_closed(n); model_recall();
    do_read(4, "R10"); do_read(3, "R10");

    tick(); tick();
    chk("R11", exp_q.size(), 0, "all reads answered");
    summary();
    $finish;
  end
endmodule